// File: doc/BRIEF.md
# Eight-Cell Pipelined FIR Filter Core

The core computes an eight-tap finite impulse response from a stream of 9-bit two's-complement samples and a separate stream of 9-bit two's-complement weights. Each input bus has its own load enable. A new sample enters on every clock. The weights arrive as a sequence that repeats every eight clocks, with the highest-index weight first. Eight multiply-accumulate cells each own one output phase. Every cell builds one complete sum over eight consecutive samples. The cells are staggered by one clock, so one finished 26-bit sum leaves the core on every clock once the pipeline has filled.

Each weight travels from cell to cell through a chain of registers. The weight in use by the last cell is driven out, so a second core can take its weights from the first. This builds a sixteen-tap filter whose two partial sums are added outside the core. Every path from an input pin to the sum output passes four register levels: the input register, two product registers, then the accumulate/output register.

Top module: `fir8_core`

## Requirements
- R1: A synchronous active-high `rst` clears every register. On the negative clock phase after any edge that samples `rst` high, `y_out` and `cof_out` read 0.
- R2: On each rising edge with `rst` low, the sample register loads `smp_in` when `smp_en` is 1 and keeps its value when `smp_en` is 0. Call the value it holds after edge t xr(t), counting t = 0 from the first edge after `rst` falls.
- R3: The weight register loads `cof_in` when `cof_en` is 1 and holds when `cof_en` is 0. Call its value after edge t cr(t).
- R4: For n >= 7, `y_out` after edge n+3 equals the sum over i = 0..7 of cr(8q+i)·xr(n−7+i), where q = floor((n−7)/8). With weights fed C7, C6 … C0 repeating from edge 0, this gives Y(n) = Σ C(k)·X(n−k) for k = 0..7.
- R5: During fill (edges 0 through 9 after reset), `y_out` is 0.
- R6: Once filled, the core delivers a new sum on every clock. Exactly one cell finishes per clock, in rotating order.
- R7: Samples and weights are two's-complement. The 18-bit products are sign-extended into a 26-bit sum, so every input value gives the exact result. With all inputs at −256, the sum is 524288.
- R8: `cof_out` after edge e equals cr(e−7) for e >= 7, and 0 before that. A chained core that samples it therefore sees the weight stream delayed by eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 9 | Signed data sample |
| smp_en | input | 1 | Load enable for the sample register |
| cof_in | input | 9 | Signed weight from the repeating stream |
| cof_en | input | 1 | Load enable for the weight register |
| cof_out | output | 9 | Weight used by the last cell, for chaining |
| y_out | output | 26 | Registered signed sum of products |

## Verification
On every cycle, assertions check the following:
- both input registers load or hold according to their enables;
- a cell's accumulator restarts from its newest product at the start of its window;
- the finishing cell rotates by one position per clock.

Only the bench's scenarios can show whether the right samples meet the right weights, and with which latency. Those scenarios are random streams, full-scale negative operands, gaps in either enable, and a reset in mid-stream. The bench compares each cycle against a convolution computed from its own record of what the input registers captured. The same holds for the eight-clock delay on the chaining output.

// File: rtl/fir8_pkg.sv
package fir8_pkg;
  // Register levels ahead of the accumulator: input register plus two product stages.
  localparam int unsigned FILL_LAG = 3;

  // Position that lies `back` steps behind `pos` on a ring of n entries (back < 2n).
  function automatic int unsigned ring_back(int unsigned pos, int unsigned back, int unsigned n);
    return (pos + 2 * n - back) % n;
  endfunction
endpackage

// File: rtl/fir8_phase.sv
module fir8_phase
  import fir8_pkg::*;
#(
  parameter int unsigned TAPS = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TAPS-1:0] first_vec,
  output logic [TAPS-1:0] last_vec
);
  localparam int unsigned CNT_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TAPS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (cnt == CNT_TOP) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // A cell opens its window FILL_LAG edges after its first weight was registered
  // and closes it TAPS-1 edges later, one position further around the ring.
  always_comb begin
    int unsigned open_idx;
    int unsigned close_idx;
    open_idx  = ring_back(int'(cnt), FILL_LAG, TAPS);
    close_idx = (open_idx + 1) % TAPS;
    for (int j = 0; j < TAPS; j++) begin
      first_vec[j] = (open_idx == j);
      last_vec[j]  = (close_idx == j);
    end
  end

  // R6: exactly one cell completes per clock, moving one place each cycle
  assert_rotate_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> last_vec == {$past(last_vec[TAPS-2:0]), $past(last_vec[TAPS-1])});
endmodule

// File: rtl/fir8_cell.sv
module fir8_cell #(
  parameter int unsigned DW = 9,
  parameter int unsigned CW = 9,
  parameter int unsigned SW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] c,
  input  logic                 first,
  output logic signed [SW-1:0] total
);
  localparam int unsigned PW = DW + CW;

  logic signed [PW-1:0] m0_q;
  logic signed [PW-1:0] m1_q;
  logic signed [SW-1:0] acc_q;
  logic signed [SW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      m0_q  <= '0;
      m1_q  <= '0;
      acc_q <= '0;
    end else begin
      m0_q  <= PW'(x) * PW'(c);
      m1_q  <= m0_q;
      acc_q <= total;
    end
  end

  always_comb begin
    base  = first ? '0 : acc_q;
    total = base + {{(SW-PW){m1_q[PW-1]}}, m1_q};
  end

  // R4/R7: a new window starts from the sign-extended newest product alone
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    first |=> acc_q == {{(SW-PW){$past(m1_q[PW-1])}}, $past(m1_q)});
endmodule

// File: rtl/fir8_pick.sv
module fir8_pick #(
  parameter int unsigned TAPS = 8,
  parameter int unsigned SW   = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] total [TAPS],
  input  logic [TAPS-1:0]      last_vec,
  output logic signed [SW-1:0] y
);
  logic signed [SW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int j = 0; j < TAPS; j++) begin
      if (last_vec[j]) sel = sel | total[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= sel;
  end
endmodule

// File: rtl/fir8_core.sv
module fir8_core #(
  parameter int unsigned TAPS = 8,
  parameter int unsigned DW   = 9,
  parameter int unsigned CW   = 9,
  parameter int unsigned SW   = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp_in,
  input  logic                 smp_en,
  input  logic signed [CW-1:0] cof_in,
  input  logic                 cof_en,
  output logic signed [CW-1:0] cof_out,
  output logic signed [SW-1:0] y_out
);
  localparam int unsigned CHAIN = TAPS - 1;

  logic signed [DW-1:0] x_q;
  logic signed [CW-1:0] c_q;
  logic signed [CW-1:0] c_dly [CHAIN];
  logic signed [CW-1:0] c_use [TAPS];
  logic signed [SW-1:0] total [TAPS];
  logic [TAPS-1:0]      first_vec;
  logic [TAPS-1:0]      last_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      c_q <= '0;
      for (int j = 0; j < CHAIN; j++) c_dly[j] <= '0;
    end else begin
      if (smp_en) x_q <= smp_in;
      if (cof_en) c_q <= cof_in;
      c_dly[0] <= c_q;
      for (int j = 1; j < CHAIN; j++) c_dly[j] <= c_dly[j-1];
    end
  end

  always_comb begin
    c_use[0] = c_q;
    for (int j = 1; j < TAPS; j++) c_use[j] = c_dly[j-1];
  end

  assign cof_out = c_use[TAPS-1];

  fir8_phase #(.TAPS(TAPS)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .first_vec (first_vec),
    .last_vec  (last_vec)
  );

  for (genvar g = 0; g < TAPS; g++) begin : g_cell
    fir8_cell #(.DW(DW), .CW(CW), .SW(SW)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .x     (x_q),
      .c     (c_use[g]),
      .first (first_vec[g]),
      .total (total[g])
    );
  end

  fir8_pick #(.TAPS(TAPS), .SW(SW)) u_pick (
    .clk      (clk),
    .rst      (rst),
    .total    (total),
    .last_vec (last_vec),
    .y        (y_out)
  );

  // R2: the sample register follows its enable
  assert_smp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(x_q));
  assert_smp_load_R2: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> x_q == $past(smp_in));
  // R3: the weight register follows its enable
  assert_cof_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cof_en |=> $stable(c_q));
  assert_cof_load_R3: assert property (@(posedge clk) disable iff (rst)
    cof_en |=> c_q == $past(cof_in));
endmodule

// File: tb/test_fir8_core.sv
module test_fir8_core;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [8:0] smp_in = '0;
  logic signed [8:0] cof_in = '0;
  logic smp_en = 1'b0;
  logic cof_en = 1'b0;
  wire  signed [8:0]    cof_out;
  wire  signed [SW-1:0] y_out;

  int checks = 0;
  int errors = 0;
  int xr[$];
  int cr[$];
  int edges = 0;
  int cidx = 0;
  string tag = "R4/R6";
  int wts[8] = '{17, -256, 3, 255, -100, 0, 42, -7};

  fir8_core i_fir8_core (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_en(smp_en),
    .cof_in(cof_in), .cof_en(cof_en), .cof_out(cof_out), .y_out(y_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_val(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edges - 1);
    end
  endtask

  task automatic check_edge();
    int e;
    int n;
    longint exp;
    e = edges - 1;
    n = e - 3;
    if (n < 7) begin
      check_val("R5 fill", longint'(y_out), 0);
    end else begin
      int q;
      q = (n - 7) / 8;
      exp = 0;
      for (int i = 0; i < 8; i++) exp += longint'(cr[8*q+i]) * longint'(xr[n-7+i]);
      check_val(tag, longint'(y_out), exp);
    end
    check_val("R8 chain", longint'(cof_out), (e >= 7) ? longint'(cr[e-7]) : 0);
  endtask

  // Drive one cycle at the falling edge, record what the input registers capture.
  task automatic step(int d, bit de, int c, bit ce);
    smp_in = 9'(d);
    smp_en = de;
    cof_in = 9'(c);
    cof_en = ce;
    xr.push_back(de ? d : ((xr.size() > 0) ? xr[$] : 0));
    cr.push_back(ce ? c : ((cr.size() > 0) ? cr[$] : 0));
    @(negedge clk);
    edges++;
    check_edge();
  endtask

  function automatic int next_wt();
    int w;
    w = wts[7 - (cidx % 8)];
    cidx++;
    return w;
  endfunction

  function automatic int rnd9();
    return int'($urandom_range(0, 511)) - 256;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    smp_en = 1'b0;
    cof_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_val("R1 reset sum", longint'(y_out), 0);
    check_val("R1 reset chain", longint'(cof_out), 0);
    rst = 1'b0;
    xr.delete();
    cr.delete();
    edges = 0;
    cidx = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R4/R6: ordered weight stream, random samples
    tag = "R4/R6 stream";
    for (int k = 0; k < 40; k++) step(rnd9(), 1'b1, next_wt(), 1'b1);
    // R7: full-scale negative operands
    tag = "R7 full scale";
    for (int k = 0; k < 24; k++) step(-256, 1'b1, -256, 1'b1);
    check_val("R7 full scale value", longint'(y_out), 524288);
    // R2: gaps in the sample enable
    tag = "R2 sample hold";
    for (int k = 0; k < 32; k++) step(rnd9(), ($urandom_range(0, 3) != 0), next_wt(), 1'b1);
    // R3: gaps in the weight enable with random weights
    tag = "R3 weight hold";
    for (int k = 0; k < 32; k++) step(rnd9(), 1'b1, rnd9(), ($urandom_range(0, 3) != 0));
    // R1: reset in mid-stream, then restart from a clean pipeline
    do_reset();
    tag = "R1 restart";
    for (int k = 0; k < 24; k++) step(rnd9(), 1'b1, next_wt(), 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule